// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port

This block is one port of general-purpose pins on a programmable logic device attached to a host processor. Each pin carries its own configuration. A per-pin multiplexer chooses what drives the pin: the host's data-out register, the logic macrocell output, or (on the chip-select port only) one of the external chip-select lines. The pin driver is enabled when either the logic-array enable term or the host direction bit for that pin is set. The bidirectional pad is modelled as separate `pin_in`, `pin_out` and `pin_oe` signals.

The host writes the data-out, direction and drive registers through a small register interface. It reads back exactly one source at a time, chosen by the read address: a stored register, the live pin levels, the macrocell outputs or the captured input values. Each pin also has an input capture cell that feeds the logic input bus (`cap_out`). The cell runs in one of three modes: a direct path, a transparent latch gated by a product term, or an edge-triggered register clocked by a product term.

In register mode, a two-state machine per pin tracks the product-term level as sampled by the host clock. In state `PT_LOW` a high product term causes a capture, and the transition `PT_LOW -> PT_HIGH` marks the rising edge. State `PT_HIGH` stays while the term remains high, and `PT_HIGH -> PT_LOW` happens when the term falls. Parameters set the port width (8, or 4 for the narrow port) and whether chip-select sources exist.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, the data-out, direction and drive registers all read 0, and `pin_oe` is 0 while `pt_oe` is 0, so every pin starts as an input.
- R2: A host write with `host_wr`=1 at address 0 (data-out), 1 (direction) or 2 (drive) updates that register on the rising clock edge. A write to any address from 3 to 7 changes none of the three registers.
- R3: `host_rdata` returns one source chosen by `host_addr`. The codes are 0 for data-out, 1 for direction, 2 for drive, 3 for the live `pin_in`, 4 for `mcell_out` and 5 for `cap_out`. Codes 6 and 7 return 0.
- R4: Pin i's drive source is chosen by `cfg_src[2i+1:2i]`. Code 0 selects data-out bit i, code 1 selects `mcell_out[i]`, and code 2 selects `cs_in[i mod NUM_CS]`. Code 3 behaves as code 0.
- R5: With `CS_EN`=0 (used for the 4-bit narrow port), code 2 selects data-out bit i, and `cs_in` has no effect on `pin_out`.
- R6: `pin_oe[i]` is the OR of `pt_oe[i]` and direction bit i. With `pt_oe[i]`=0, the direction bit alone controls the driver.
- R7: In capture mode 0 (`cfg_cap[2i+1:2i]`=0, and also for code 3), `cap_out[i]` equals `pin_in[i]` in the same cycle.
- R8: In capture mode 1 (latch), `cap_out[i]` follows `pin_in[i]` while `pt_cap[i]` is 1. While `pt_cap[i]` is 0, it holds the value `pin_in[i]` had at the last clock edge where `pt_cap[i]` was 1 (0 after reset).
- R9: In capture mode 2 (register), `cap_out[i]` takes `pin_in[i]` at a clock edge where `pt_cap[i]` is 1 and was 0 at the previous edge. Otherwise it stays constant, including while `pt_cap[i]` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register / readback address |
| host_wdata | input | WIDTH | Write data |
| host_rdata | output | WIDTH | Readback data |
| cfg_src | input | 2*WIDTH | Per-pin drive-source code |
| cfg_cap | input | 2*WIDTH | Per-pin capture-mode code |
| mcell_out | input | WIDTH | Logic macrocell outputs |
| pt_oe | input | WIDTH | Array output-enable product terms |
| pt_cap | input | WIDTH | Array capture clock/enable product terms |
| cs_in | input | NUM_CS | External chip-select lines |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad driver enables |
| cap_out | output | WIDTH | Captured inputs to the logic input bus |

## Verification
Several results are combinational and due in the same cycle as their inputs: pin output values, driver enables, bypass and transparent-latch capture, and readback of any selected source. The bench changes these inputs on a falling edge and samples a nanosecond later. Register writes and register-mode captures appear only after the next rising edge, so the bench drives them on a falling edge and checks them at the following falling edge. For register mode, the bench also samples one cycle later with the product term still high and expects no change. Latch hold is checked after the product term is lowered away from an edge and the pin is then changed.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

    localparam logic [1:0] SRC_DOUT  = 2'd0;
    localparam logic [1:0] SRC_MCELL = 2'd1;
    localparam logic [1:0] SRC_CSEL  = 2'd2;

    localparam logic [1:0] CAP_BYPASS = 2'd0;
    localparam logic [1:0] CAP_LATCH  = 2'd1;
    localparam logic [1:0] CAP_REG    = 2'd2;

    localparam logic [2:0] ADDR_DOUT  = 3'd0;
    localparam logic [2:0] ADDR_DIR   = 3'd1;
    localparam logic [2:0] ADDR_DRIVE = 3'd2;
    localparam logic [2:0] ADDR_PIN   = 3'd3;
    localparam logic [2:0] ADDR_MCELL = 3'd4;
    localparam logic [2:0] ADDR_CAP   = 3'd5;

    typedef enum logic {
        PT_LOW  = 1'b0,
        PT_HIGH = 1'b1
    } pt_state_e;

endpackage

// File: rtl/io_host_regs.sv
module io_host_regs
    import io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_lvl,
    input  logic [WIDTH-1:0] mcell_lvl,
    input  logic [WIDTH-1:0] cap_lvl,
    output logic [WIDTH-1:0] dout_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] drive_q,
    output logic [WIDTH-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            drive_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_DOUT:  dout_q  <= wdata;
                ADDR_DIR:   dir_q   <= wdata;
                ADDR_DRIVE: drive_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_DOUT:  rdata = dout_q;
            ADDR_DIR:   rdata = dir_q;
            ADDR_DRIVE: rdata = drive_q;
            ADDR_PIN:   rdata = pin_lvl;
            ADDR_MCELL: rdata = mcell_lvl;
            ADDR_CAP:   rdata = cap_lvl;
            default:    rdata = '0;
        endcase
    end

    // R2: a data-out write lands on the edge
    a_r2_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_DOUT) |=> (dout_q == $past(wdata)));

    // R2: writes outside the register addresses leave all registers alone
    a_r2_bad_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_DRIVE) |=> ($stable(dout_q) && $stable(dir_q) && $stable(drive_q)));

endmodule

// File: rtl/io_out_stage.sv
module io_out_stage
    import io_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit CS_EN  = 1'b1,
    parameter int NUM_CS = 8
) (
    input  logic [2*WIDTH-1:0] cfg_src,
    input  logic [WIDTH-1:0]   dout_q,
    input  logic [WIDTH-1:0]   dir_q,
    input  logic [WIDTH-1:0]   mcell_in,
    input  logic [WIDTH-1:0]   pt_oe,
    input  logic [NUM_CS-1:0]  cs_in,
    output logic [WIDTH-1:0]   pin_out,
    output logic [WIDTH-1:0]   pin_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        localparam int CSI = i % NUM_CS;
        logic [1:0] code;
        logic       cs_bit;

        assign code = cfg_src[2*i +: 2];

        if (CS_EN) begin : g_cs
            assign cs_bit = cs_in[CSI];
        end else begin : g_no_cs
            assign cs_bit = dout_q[i];
        end

        always_comb begin
            unique case (code)
                SRC_MCELL: pin_out[i] = mcell_in[i];
                SRC_CSEL:  pin_out[i] = cs_bit;
                default:   pin_out[i] = dout_q[i];
            endcase
        end

        assign pin_oe[i] = pt_oe[i] | dir_q[i];
    end

    if (!CS_EN) begin : g_cs_unused
        logic cs_unused;
        assign cs_unused = ^cs_in;
    end

endmodule

// File: rtl/io_capture_cell.sv
module io_capture_cell
    import io_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       pt_cap,
    input  logic       pin_in,
    output logic       cap_out
);

    pt_state_e state_q, state_d;
    logic      held_q;
    logic      take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PT_LOW;
        else        state_q <= state_d;
    end

    // next state: follows the sampled product-term level
    always_comb begin
        unique case (state_q)
            PT_LOW:  state_d = pt_cap ? PT_HIGH : PT_LOW;
            PT_HIGH: state_d = pt_cap ? PT_HIGH : PT_LOW;
            default: state_d = PT_LOW;
        endcase
    end

    always_comb begin
        unique case (mode)
            CAP_REG:   take = pt_cap && (state_q == PT_LOW);
            CAP_LATCH: take = pt_cap;
            default:   take = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    held_q <= 1'b0;
        else if (take) held_q <= pin_in;
    end

    // outputs
    always_comb begin
        unique case (mode)
            CAP_LATCH: cap_out = pt_cap ? pin_in : held_q;
            CAP_REG:   cap_out = held_q;
            default:   cap_out = pin_in;
        endcase
    end

    // R9: rising product term captures the pin
    a_r9_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_REG && state_q == PT_LOW && pt_cap) |=> (held_q == $past(pin_in)));

    // R9: no capture while the term stays high
    a_r9_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_REG && state_q == PT_HIGH) |=> $stable(held_q));

    // R8: latch is closed while the term is low
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAP_LATCH && !pt_cap) |=> $stable(held_q));

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import io_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter bit CS_EN  = 1'b1,
    parameter int NUM_CS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic [2:0]           host_addr,
    input  logic [WIDTH-1:0]     host_wdata,
    output logic [WIDTH-1:0]     host_rdata,
    input  logic [2*WIDTH-1:0]   cfg_src,
    input  logic [2*WIDTH-1:0]   cfg_cap,
    input  logic [WIDTH-1:0]     mcell_out,
    input  logic [WIDTH-1:0]     pt_oe,
    input  logic [WIDTH-1:0]     pt_cap,
    input  logic [NUM_CS-1:0]    cs_in,
    input  logic [WIDTH-1:0]     pin_in,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_oe,
    output logic [WIDTH-1:0]     cap_out
);

    logic [WIDTH-1:0] dout_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] drive_q;

    io_host_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .pin_lvl  (pin_in),
        .mcell_lvl(mcell_out),
        .cap_lvl  (cap_out),
        .dout_q   (dout_q),
        .dir_q    (dir_q),
        .drive_q  (drive_q),
        .rdata    (host_rdata)
    );

    io_out_stage #(.WIDTH(WIDTH), .CS_EN(CS_EN), .NUM_CS(NUM_CS)) u_out (
        .cfg_src (cfg_src),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .mcell_in(mcell_out),
        .pt_oe   (pt_oe),
        .cs_in   (cs_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cap
        io_capture_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (cfg_cap[2*i +: 2]),
            .pt_cap (pt_cap[i]),
            .pin_in (pin_in[i]),
            .cap_out(cap_out[i])
        );

        // R6: without an array enable, the direction bit owns the driver
        a_r6_dir_alone: assert property (@(posedge clk) disable iff (!rst_n)
            !pt_oe[i] |-> (pin_oe[i] == dir_q[i]));

        // R6: an array enable always turns the driver on
        a_r6_pt_enables: assert property (@(posedge clk) disable iff (!rst_n)
            pt_oe[i] |-> pin_oe[i]);
    end

endmodule

// File: tb/cfg_io_port_bench.sv
module cfg_io_port_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0;
    logic [2:0]   host_addr = '0;
    logic [W-1:0] host_wdata = '0;
    logic [W-1:0] host_rdata;
    logic [15:0]  cfg_src = '0;
    logic [15:0]  cfg_cap = '0;
    logic [W-1:0] mcell_out = '0;
    logic [W-1:0] pt_oe = '0;
    logic [W-1:0] pt_cap = '0;
    logic [7:0]   cs_in = '0;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe, cap_out;

    logic         n_wr = 1'b0;
    logic [2:0]   n_addr = '0;
    logic [3:0]   n_wdata = '0;
    logic [3:0]   n_rdata, n_pin_out, n_pin_oe, n_cap_out;
    logic [7:0]   n_cfg_src = '0;
    logic [0:0]   n_cs = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfg_io_port u_cfg_io_port (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_src(cfg_src),
        .cfg_cap(cfg_cap), .mcell_out(mcell_out), .pt_oe(pt_oe), .pt_cap(pt_cap),
        .cs_in(cs_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .cap_out(cap_out)
    );

    cfg_io_port #(.WIDTH(4), .CS_EN(1'b0), .NUM_CS(1)) u_narrow (
        .clk(clk), .rst_n(rst_n), .host_wr(n_wr), .host_addr(n_addr),
        .host_wdata(n_wdata), .host_rdata(n_rdata), .cfg_src(n_cfg_src),
        .cfg_cap(8'h00), .mcell_out(4'h0), .pt_oe(4'h0), .pt_cap(4'h0),
        .cs_in(n_cs), .pin_in(4'h0), .pin_out(n_pin_out), .pin_oe(n_pin_oe),
        .cap_out(n_cap_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [W-1:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic t_reset();
        logic [W-1:0] d;
        host_read(3'd0, d); check("R1 dout after reset", d, 8'h00);
        host_read(3'd1, d); check("R1 dir after reset", d, 8'h00);
        host_read(3'd2, d); check("R1 drive after reset", d, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);
    endtask

    task automatic t_regs();
        logic [W-1:0] d;
        host_write(3'd0, 8'h5A);
        host_write(3'd1, 8'hC3);
        host_write(3'd2, 8'h99);
        host_read(3'd0, d); check("R2 dout write", d, 8'h5A);
        host_read(3'd1, d); check("R2 dir write", d, 8'hC3);
        host_read(3'd2, d); check("R2 drive write", d, 8'h99);
        for (int a = 3; a < 8; a++) host_write(3'(a), 8'hFF);
        host_read(3'd0, d); check("R2 dout untouched by high address", d, 8'h5A);
        host_read(3'd1, d); check("R2 dir untouched by high address", d, 8'hC3);
        host_read(3'd2, d); check("R2 drive untouched by high address", d, 8'h99);
    endtask

    task automatic t_readback();
        logic [W-1:0] d;
        @(negedge clk);
        pin_in = 8'h6E; mcell_out = 8'h17;
        host_read(3'd3, d); check("R3 read pin levels", d, 8'h6E);
        host_read(3'd4, d); check("R3 read macrocells", d, 8'h17);
        cfg_cap = 16'h0000;
        host_read(3'd5, d); check("R3 read capture (bypass)", d, 8'h6E);
        host_read(3'd6, d); check("R3 code 6 reads zero", d, 8'h00);
        host_read(3'd7, d); check("R3 code 7 reads zero", d, 8'h00);
    endtask

    task automatic t_out_mux();
        host_write(3'd0, 8'h0F);
        @(negedge clk);
        mcell_out = 8'h33; cs_in = 8'hA5;
        cfg_src = 16'h0000; #1; check("R4 code0 data-out", pin_out, 8'h0F);
        cfg_src = 16'h5555; #1; check("R4 code1 macrocell", pin_out, 8'h33);
        cfg_src = 16'hAAAA; #1; check("R4 code2 chip-select", pin_out, 8'hA5);
        cfg_src = 16'hFFFF; #1; check("R4 code3 as data-out", pin_out, 8'h0F);
        cfg_src = 16'hAA55; #1; check("R4 mixed sources", pin_out, 8'hA3);
        cs_in = 8'h5A;      #1; check("R4 chip-select follows line", pin_out, 8'h53);
    endtask

    task automatic t_narrow();
        logic [3:0] d;
        @(negedge clk);
        n_wr = 1'b1; n_addr = 3'd0; n_wdata = 4'hA;
        @(negedge clk);
        n_wr = 1'b0;
        n_cfg_src = 8'hAA; n_cs = 1'b1; #1;
        d = n_pin_out;
        check("R5 narrow code2 gives data-out", d, 4'hA);
        n_cs = 1'b0; #1;
        check("R5 narrow cs_in has no effect", n_pin_out, 4'hA);
        check("R1 narrow oe after reset", n_pin_oe, 4'h0);
    endtask

    task automatic t_oe();
        host_write(3'd1, 8'h00);
        pt_oe = 8'h00; #1; check("R6 all inputs", pin_oe, 8'h00);
        host_write(3'd1, 8'hF0);
        #1; check("R6 dir alone", pin_oe, 8'hF0);
        pt_oe = 8'h0C; #1; check("R6 OR with product term", pin_oe, 8'hFC);
        host_write(3'd1, 8'h00);
        pt_oe = 8'h81; #1; check("R6 product term alone", pin_oe, 8'h81);
        pt_oe = 8'h00;
    endtask

    task automatic t_bypass();
        @(negedge clk);
        cfg_cap = 16'h0000; pin_in = 8'hC3; #1;
        check("R7 bypass same cycle", cap_out, 8'hC3);
        pin_in = 8'h24; #1;
        check("R7 bypass follows pin", cap_out, 8'h24);
        cfg_cap = 16'hFFFF; #1;
        check("R7 code3 acts as bypass", cap_out, 8'h24);
    endtask

    task automatic t_latch();
        @(negedge clk);
        cfg_cap = 16'h5555; pt_cap = 8'h00; pin_in = 8'h3C; #1;
        check("R8 closed latch holds reset value", cap_out, 8'h00);
        pt_cap = 8'hFF; #1;
        check("R8 transparent", cap_out, 8'h3C);
        pin_in = 8'h5A; #1;
        check("R8 transparent follows pin", cap_out, 8'h5A);
        @(negedge clk);
        pt_cap = 8'h00; pin_in = 8'h0F; #1;
        check("R8 holds after close", cap_out, 8'h5A);
        @(negedge clk); #1;
        check("R8 still held one cycle later", cap_out, 8'h5A);
    endtask

    task automatic t_register();
        logic [W-1:0] d;
        @(negedge clk);
        cfg_cap = 16'hAAAA; pt_cap = 8'h00; pin_in = 8'h81;
        @(negedge clk);
        pt_cap = 8'hFF; #1;
        check("R9 no change before edge", cap_out, 8'h5A);
        @(negedge clk); #1;
        check("R9 captured on rising term", cap_out, 8'h81);
        pin_in = 8'h7E;
        @(negedge clk); #1;
        check("R9 no capture while term high", cap_out, 8'h81);
        pt_cap = 8'h00;
        @(negedge clk); #1;
        check("R9 no capture on falling term", cap_out, 8'h81);
        pt_cap = 8'hFF;
        @(negedge clk); #1;
        check("R9 second rising term captures", cap_out, 8'h7E);
        host_read(3'd5, d);
        check("R3 capture readback in register mode", d, 8'h7E);
        pt_cap = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_readback();
        t_out_mux();
        t_narrow();
        t_oe();
        t_bypass();
        t_latch();
        t_register();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule